// File: doc/BRIEF.md
# Nonvolatile Memory Write-Protection Key Controller

This block decides whether a write to on-chip nonvolatile storage may proceed. It watches a small register bus and tracks a lock state for two key-protected areas. One is program memory. The other is data EEPROM, and the option-byte area goes with it. Every memory write request is checked against that state. The block returns one write-enable qualifier per area, registered one cycle after the request.

Both areas are locked out of reset. Each area opens only after its own two-byte key sequence arrives in the right order at its key register. A wrong key leaves that area locked until the next reset.

At the bottom of program memory sits a boot-code window. Its size comes from a page-count input, with pages of 512 bytes. No key sequence can ever open this window.

A write that is refused while it falls inside a protected area sets a sticky violation flag. Reading the status register clears the flag.

A read-out protection bit is also held here. Any write that changes it raises a one-cycle global-erase request.

Top module: `fwp_guard`

## Requirements
- R1: After reset, status (offset 2) reads 0x00, the read-out bit (offset 3) reads 0x00, no write qualifier is asserted for any address, and erase_req is low.
- R2: Writing 0x56 and then 0xAE to offset 0 opens program memory. Status bit 0 then reads 1, and a request to 0x8000..0xFFFF outside the boot window raises pgm_we_ok in the next cycle.
- R3: Writing 0xAE and then 0x56 to offset 1 opens data EEPROM (0x4000..0x43FF, eep_we_ok) and the option bytes (0x4800..0x487F, opt_we_ok). Status bit 1 then reads 1. While this area is locked, requests to these ranges get no qualifier.
- R4: The boot window runs from 0x8000 for boot_pages×512 bytes. A request inside it never gets pgm_we_ok, even with program memory open. A value of 0 means no window, and 64 or more covers all of program memory.
- R5: Any key write that breaks the expected sequence for an area keeps that area locked until reset. This covers a wrong value as well as a correct value in the wrong place. A later correct sequence then has no effect.
- R6: Writing offset 2 with bit 0 (or bit 1) at 0 relocks an open program (or data) area. A fresh key sequence opens it again. Writing 1 to these bits has no effect.
- R7: A request that falls in any of the three areas and is refused sets status bit 2. The bit stays set until a status read returns it, and that read clears it. A request outside all areas sets nothing.
- R8: Offset 3 bit 0 holds the read-out protection state. A write whose bit 0 differs from the held value updates it and pulses erase_req for exactly one cycle, the cycle after the write. A write of the same value leaves erase_req low.
- R9: At most one write qualifier is high in any cycle, and only in the cycle after a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register offset (0 program key, 1 data key, 2 status, 3 read-out) |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd |
| boot_pages | input | 8 | Boot window size in 512-byte pages |
| mw_req | input | 1 | Memory write request |
| mw_addr | input | 16 | Memory write byte address |
| pgm_we_ok | output | 1 | Program memory write allowed |
| eep_we_ok | output | 1 | Data EEPROM write allowed |
| opt_we_ok | output | 1 | Option-byte write allowed |
| erase_req | output | 1 | Global erase request pulse |

## Verification
The assertions assume that boot_pages is stable for the cycle in which a request is checked against it. They also assume that bus_wr and bus_rd each act on a single offset per cycle, and that mw_req carries a valid address whenever it is high.

The bench changes boot_pages only while mw_req is low. It raises one strobe at a time, and it holds every request for exactly one cycle. Under these conditions the registered qualifiers and the violation flag have a single expected value in each checked cycle.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_HALF   = 2'd1,
    KS_OPEN   = 2'd2,
    KS_JAMMED = 2'd3
  } key_state_t;

  localparam logic [1:0] REG_PKEY = 2'd0;
  localparam logic [1:0] REG_DKEY = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;
  localparam logic [1:0] REG_ROP  = 2'd3;

  localparam int STAT_POPEN = 0;
  localparam int STAT_DOPEN = 1;
  localparam int STAT_WPV   = 2;
endpackage

// File: rtl/fwp_key_seq.sv
module fwp_key_seq
  import fwp_pkg::*;
#(
  parameter int KEY_W = 8,
  parameter logic [KEY_W-1:0] FIRST  = 'h56,
  parameter logic [KEY_W-1:0] SECOND = 'hAE
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key_val,
  input  logic             relock,
  output logic             is_open
);
  key_state_t state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= KS_LOCKED;
    end else begin
      case (state_q)
        KS_LOCKED: if (key_wr) state_q <= (key_val == FIRST)  ? KS_HALF : KS_JAMMED;
        KS_HALF:   if (key_wr) state_q <= (key_val == SECOND) ? KS_OPEN : KS_JAMMED;
        KS_OPEN:   if (relock) state_q <= KS_LOCKED;
        default:   state_q <= KS_JAMMED;
      endcase
    end
  end

  assign is_open = (state_q == KS_OPEN);
endmodule

// File: rtl/fwp_decode.sv
module fwp_decode #(
  parameter int ADDR_W     = 16,
  parameter int BOOT_W     = 8,
  parameter int PAGE_BYTES = 512,
  parameter logic [ADDR_W-1:0] PGM_BASE = 'h8000,
  parameter int PGM_BYTES  = 32768,
  parameter logic [ADDR_W-1:0] EEP_BASE = 'h4000,
  parameter int EEP_BYTES  = 1024,
  parameter logic [ADDR_W-1:0] OPT_BASE = 'h4800,
  parameter int OPT_BYTES  = 128
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BOOT_W-1:0] boot_pages,
  output logic              in_pgm,
  output logic              in_eep,
  output logic              in_opt,
  output logic              in_boot
);
  localparam int PAGE_LSB = $clog2(PAGE_BYTES);
  localparam int PG_W     = ADDR_W - PAGE_LSB;
  localparam int CMP_W    = ((PG_W > BOOT_W) ? PG_W : BOOT_W) + 1;
  localparam logic [ADDR_W:0] PGM_LIM = (ADDR_W+1)'(PGM_BYTES);
  localparam logic [ADDR_W:0] EEP_LIM = (ADDR_W+1)'(EEP_BYTES);
  localparam logic [ADDR_W:0] OPT_LIM = (ADDR_W+1)'(OPT_BYTES);

  logic [ADDR_W-1:0] pgm_off, eep_off, opt_off;
  logic [PG_W-1:0]   page;

  // Offsets wrap for addresses below a base, so one unsigned compare covers both ends.
  assign pgm_off = addr - PGM_BASE;
  assign eep_off = addr - EEP_BASE;
  assign opt_off = addr - OPT_BASE;
  assign page    = pgm_off[ADDR_W-1:PAGE_LSB];

  assign in_pgm  = {1'b0, pgm_off} < PGM_LIM;
  assign in_eep  = {1'b0, eep_off} < EEP_LIM;
  assign in_opt  = {1'b0, opt_off} < OPT_LIM;
  assign in_boot = in_pgm && (CMP_W'(page) < CMP_W'(boot_pages));
endmodule

// File: rtl/fwp_guard.sv
module fwp_guard
  import fwp_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int BOOT_W     = 8,
  parameter int PAGE_BYTES = 512,
  parameter logic [ADDR_W-1:0] PGM_BASE = 'h8000,
  parameter int PGM_BYTES  = 32768,
  parameter logic [ADDR_W-1:0] EEP_BASE = 'h4000,
  parameter int EEP_BYTES  = 1024,
  parameter logic [ADDR_W-1:0] OPT_BASE = 'h4800,
  parameter int OPT_BYTES  = 128,
  parameter logic [DATA_W-1:0] KEY_A = 'h56,
  parameter logic [DATA_W-1:0] KEY_B = 'hAE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [BOOT_W-1:0] boot_pages,
  input  logic              mw_req,
  input  logic [ADDR_W-1:0] mw_addr,
  output logic              pgm_we_ok,
  output logic              eep_we_ok,
  output logic              opt_we_ok,
  output logic              erase_req
);
  logic pgm_open, eep_open;
  logic in_pgm, in_eep, in_opt, in_boot;
  logic pgm_ok, eep_ok, opt_ok, viol;
  logic wpv_q, rop_q;
  logic pkey_wr, dkey_wr, stat_wr, stat_rd, rop_wr;
  logic [DATA_W-1:0] rd_mux;

  assign pkey_wr = bus_wr && (bus_addr == REG_PKEY);
  assign dkey_wr = bus_wr && (bus_addr == REG_DKEY);
  assign stat_wr = bus_wr && (bus_addr == REG_STAT);
  assign rop_wr  = bus_wr && (bus_addr == REG_ROP);
  assign stat_rd = bus_rd && (bus_addr == REG_STAT);

  // Program area: A then B. Data/option area: B then A.
  fwp_key_seq #(.KEY_W(DATA_W), .FIRST(KEY_A), .SECOND(KEY_B)) u_pkey (
    .clk(clk), .rst(rst), .key_wr(pkey_wr), .key_val(bus_wdata),
    .relock(stat_wr && !bus_wdata[STAT_POPEN]), .is_open(pgm_open)
  );

  fwp_key_seq #(.KEY_W(DATA_W), .FIRST(KEY_B), .SECOND(KEY_A)) u_dkey (
    .clk(clk), .rst(rst), .key_wr(dkey_wr), .key_val(bus_wdata),
    .relock(stat_wr && !bus_wdata[STAT_DOPEN]), .is_open(eep_open)
  );

  fwp_decode #(
    .ADDR_W(ADDR_W), .BOOT_W(BOOT_W), .PAGE_BYTES(PAGE_BYTES),
    .PGM_BASE(PGM_BASE), .PGM_BYTES(PGM_BYTES),
    .EEP_BASE(EEP_BASE), .EEP_BYTES(EEP_BYTES),
    .OPT_BASE(OPT_BASE), .OPT_BYTES(OPT_BYTES)
  ) u_dec (
    .addr(mw_addr), .boot_pages(boot_pages),
    .in_pgm(in_pgm), .in_eep(in_eep), .in_opt(in_opt), .in_boot(in_boot)
  );

  assign pgm_ok = mw_req && in_pgm && !in_boot && pgm_open;
  assign eep_ok = mw_req && in_eep && eep_open;
  assign opt_ok = mw_req && in_opt && eep_open;
  assign viol   = mw_req && (in_pgm || in_eep || in_opt) && !(pgm_ok || eep_ok || opt_ok);

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      REG_STAT: begin
        rd_mux[STAT_POPEN] = pgm_open;
        rd_mux[STAT_DOPEN] = eep_open;
        rd_mux[STAT_WPV]   = wpv_q;
      end
      REG_ROP:  rd_mux[0] = rop_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      pgm_we_ok <= 1'b0;
      eep_we_ok <= 1'b0;
      opt_we_ok <= 1'b0;
      erase_req <= 1'b0;
      wpv_q     <= 1'b0;
      rop_q     <= 1'b0;
    end else begin
      pgm_we_ok <= pgm_ok;
      eep_we_ok <= eep_ok;
      opt_we_ok <= opt_ok;
      if (bus_rd) bus_rdata <= rd_mux;
      // A new violation wins over the clearing read in the same cycle.
      if (viol)         wpv_q <= 1'b1;
      else if (stat_rd) wpv_q <= 1'b0;
      erase_req <= 1'b0;
      if (rop_wr && (bus_wdata[0] != rop_q)) begin
        rop_q     <= bus_wdata[0];
        erase_req <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fwp_checker.sv
module fwp_checker #(
  parameter int ADDR_W   = 16,
  parameter int BOOT_W   = 8,
  parameter int PAGE_LSB = 9,
  parameter logic [ADDR_W-1:0] PGM_BASE = 'h8000
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [1:0]        bus_addr,
  input logic [BOOT_W-1:0] boot_pages,
  input logic              mw_req,
  input logic [ADDR_W-1:0] mw_addr,
  input logic              pgm_we_ok,
  input logic              eep_we_ok,
  input logic              opt_we_ok,
  input logic              erase_req,
  input logic              wpv,
  input logic              pgm_open,
  input logic              eep_open
);
  logic [ADDR_W-1:0] pg;
  logic              in_win;
  assign pg     = (mw_addr - PGM_BASE) >> PAGE_LSB;
  assign in_win = (mw_addr >= PGM_BASE) && ({1'b0, pg} < (ADDR_W+1)'(boot_pages));

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pgm_we_ok, eep_we_ok, opt_we_ok})); // R9
  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    (pgm_we_ok || eep_we_ok || opt_we_ok) |-> $past(mw_req)); // R9
  AST_PGM_NEEDS_KEY: assert property (@(posedge clk) disable iff (rst)
    pgm_we_ok |-> $past(pgm_open)); // R2
  AST_EEP_NEEDS_KEY: assert property (@(posedge clk) disable iff (rst)
    (eep_we_ok || opt_we_ok) |-> $past(eep_open)); // R3
  AST_BOOT_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (mw_req && in_win) |=> !pgm_we_ok); // R4
  AST_ERASE_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    erase_req |-> $past(bus_wr && (bus_addr == 2'd3))); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    ($past(wpv) && !$past(bus_rd && (bus_addr == 2'd2))) |-> wpv); // R7
endmodule

bind fwp_guard fwp_checker u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .boot_pages(boot_pages), .mw_req(mw_req), .mw_addr(mw_addr),
  .pgm_we_ok(pgm_we_ok), .eep_we_ok(eep_we_ok), .opt_we_ok(opt_we_ok),
  .erase_req(erase_req), .wpv(wpv_q), .pgm_open(pgm_open), .eep_open(eep_open)
);

// File: tb/tb_fwp_guard.sv
module tb_fwp_guard;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0, bus_rdata;
  logic [7:0]  boot_pages = 8'd4;
  logic        mw_req = 1'b0;
  logic [15:0] mw_addr = '0;
  logic        pgm_we_ok, eep_we_ok, opt_we_ok, erase_req;
  int n_chk = 0, n_fail = 0;
  logic [7:0] rd;
  logic [2:0] g;

  always #5 clk = ~clk;

  fwp_guard dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .boot_pages(boot_pages),
    .mw_req(mw_req), .mw_addr(mw_addr), .pgm_we_ok(pgm_we_ok),
    .eep_we_ok(eep_we_ok), .opt_we_ok(opt_we_ok), .erase_req(erase_req)
  );

  // {address, pgm, eep, opt} with both areas open and a 4-page boot window
  localparam logic [18:0] VEC [11] = '{
    {16'h8000, 3'b000}, {16'h87FF, 3'b000}, {16'h8800, 3'b100}, {16'hFFFF, 3'b100},
    {16'h4000, 3'b010}, {16'h43FF, 3'b010}, {16'h4400, 3'b000}, {16'h4800, 3'b001},
    {16'h487F, 3'b001}, {16'h4880, 3'b000}, {16'h7FFF, 3'b000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rdreg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic mtry(input logic [15:0] a, output logic [2:0] q);
    @(negedge clk); mw_req = 1'b1; mw_addr = a;
    @(negedge clk); mw_req = 1'b0; q = {pgm_we_ok, eep_we_ok, opt_we_ok};
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    rdreg(2'd2, rd); check("R1 status", rd, 8'h00);
    rdreg(2'd3, rd); check("R1 rop", rd, 8'h00);
    check("R1 erase", erase_req, 0);
    mtry(16'h9000, g); check("R1 locked grant", g, 0);
    rdreg(2'd2, rd); check("R7 flag set", rd, 8'h04);
    rdreg(2'd2, rd); check("R7 flag cleared", rd, 8'h00);
    // R2 program unlock
    wr(2'd0, 8'h56); wr(2'd0, 8'hAE);
    mtry(16'h4000, g); check("R3 eep locked", g, 0);
    rdreg(2'd2, rd); check("R2 program open", rd, 8'h05);
    // R3 data unlock
    wr(2'd1, 8'hAE); wr(2'd1, 8'h56);
    rdreg(2'd2, rd); check("R3 data open", rd, 8'h03);
    for (int i = 0; i < 11; i++) begin
      mtry(VEC[i][18:3], g);
      check($sformatf("R2/R3/R4 vector %0d", i), g, VEC[i][2:0]);
    end
    @(negedge clk); check("R9 no grant idle", {pgm_we_ok, eep_we_ok, opt_we_ok}, 0);
    rdreg(2'd2, rd); check("R7 boot reject flag", rd, 8'h07);
    mtry(16'h2000, g); check("R7 outside grant", g, 0);
    rdreg(2'd2, rd); check("R7 outside no flag", rd, 8'h03);
    // R4 window size edges
    boot_pages = 8'd0;  mtry(16'h8000, g); check("R4 zero window", g, 3'b100);
    boot_pages = 8'd64; mtry(16'hFFFF, g); check("R4 full window", g, 0);
    boot_pages = 8'd200; mtry(16'hC000, g); check("R4 oversize window", g, 0);
    boot_pages = 8'd1;  mtry(16'h81FF, g); check("R4 last boot byte", g, 0);
    mtry(16'h8200, g); check("R4 first free byte", g, 3'b100);
    // R6 relock and reopen
    wr(2'd2, 8'h02);
    rdreg(2'd2, rd); check("R6 program relocked", rd, 8'h06);
    mtry(16'h9000, g); check("R6 relocked grant", g, 0);
    wr(2'd0, 8'h56); wr(2'd0, 8'hAE);
    rdreg(2'd2, rd); check("R6 reopened", rd, 8'h07);
    wr(2'd2, 8'h01);
    rdreg(2'd2, rd); check("R6 data relocked", rd, 8'h01);
    // R8 read-out protection
    wr(2'd3, 8'h01); check("R8 erase pulse", erase_req, 1);
    @(negedge clk); check("R8 pulse one cycle", erase_req, 0);
    rdreg(2'd3, rd); check("R8 rop set", rd, 8'h01);
    wr(2'd3, 8'h01); check("R8 same value no erase", erase_req, 0);
    wr(2'd3, 8'h00); check("R8 clear erases", erase_req, 1);
    // R5 wrong keys jam until reset
    do_reset();
    wr(2'd0, 8'hAE); wr(2'd0, 8'h56); wr(2'd0, 8'hAE);
    wr(2'd1, 8'hAE); wr(2'd1, 8'h12); wr(2'd1, 8'hAE); wr(2'd1, 8'h56);
    rdreg(2'd2, rd); check("R5 both jammed", rd, 8'h00);
    mtry(16'h9000, g); check("R5 program grant", g, 0);
    mtry(16'h4000, g); check("R5 eep grant", g, 0);
    do_reset();
    wr(2'd0, 8'h56); wr(2'd0, 8'hAE);
    rdreg(2'd2, rd); check("R5 reset frees key", rd, 8'h01);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule